// File: doc/BRIEF.md
# Strided Input Sample Formatter

This block walks a byte-addressed local memory in a two-level strided pattern and hands one formatted complex sample per clock to a processing core that works on 24-bit real and imaginary parts. A job is launched with a single-cycle `start` pulse. Every configuration input is captured in that cycle, so the inputs may change freely while the job runs. Within one iteration the read address moves by a sample stride. Each new iteration begins at the previous iteration's first address plus an iteration stride. Iterations follow one another with no idle cycles. All address arithmetic wraps modulo 64 KB.

Each memory response is 64 bits wide and arrives a fixed `LAT` cycles after its request. `mem_rvalid` qualifies the response. Parts stored as 16 bits are widened to 24 bits by a left shift, with sign or zero fill above them. Parts stored as 32 bits are narrowed by dropping a chosen number of MSBs, with saturation. In real mode the imaginary output is held at zero. When an iteration holds fewer data samples than the FFT length, zero samples fill the gap and no read is issued for them.

The controller has four states. IDLE waits for `start`. READ issues one read per cycle and goes to PAD after the last data sample of an iteration when padding is needed. It stays in READ for the next iteration, or goes to DRAIN after the final slot of the last iteration. PAD issues one zero slot per cycle. It returns to READ at the end of an iteration, or goes to DRAIN at the end of the job. DRAIN waits until the final sample has left the output register and then returns to IDLE. `done` pulses in the following cycle.

Top module: `sfmt_top`

## Requirements
- R1: After reset, `mem_req`, `out_valid` and `done` are low, and they stay low until `start` is pulsed.
- R2: Data sample s of iteration i is read from address `cfg_base + i*cfg_stride_i + s*cfg_stride_s` modulo 65536. Each iteration issues exactly `cfg_last_s+1` reads, and padded slots issue none.
- R3: Slots are issued one per clock with no gap for the whole job. The first output appears `LAT+2` cycles after the cycle in which `start` is high. Each data slot is formed from the response present `LAT` cycles after its request.
- R4: Each iteration emits max(`cfg_last_s+1`, 2^L) samples, where L is `cfg_fft_log2` limited to 12. The slots after the data samples carry zero in both parts.
- R5: With `cfg_real`=1, the real part comes from response bits [15:0] (16-bit mode) or [31:0] (32-bit mode), and `out_im` is zero.
- R6: With `cfg_real`=0, 16-bit mode takes the real part from bits [15:0] and the imaginary part from bits [31:16]. 32-bit mode takes the real part from bits [31:0] and the imaginary part from bits [63:32].
- R7: In 16-bit mode (`cfg_wide`=0), a part is sign-extended (`cfg_signed`=1) or zero-extended to 24 bits and then shifted left by n = min(`cfg_shift`, 8).
- R8: In 32-bit mode, with n = min(`cfg_shift`, 8), the result is bits [31-n:8-n]. In signed mode it saturates to 0x7FFFFF or 0x800000 (by bit 31) when bits [31:31-n] are not all equal. In unsigned mode it saturates to 0xFFFFFF when any of bits [31:32-n] is set.
- R9: A job runs `cfg_last_i+1` iterations back to back and emits (`cfg_last_i+1`) times the per-iteration count of samples.
- R10: `done` is a one-cycle pulse in the cycle right after the job's final output sample.
- R11: A `start` pulse while a job is running is ignored. Changing the configuration inputs during a job does not alter that job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a job and captures the configuration (ignored when busy) |
| cfg_base | input | 16 | Byte address of the first sample |
| cfg_stride_s | input | 16 | Byte step between samples within an iteration |
| cfg_stride_i | input | 16 | Byte step between the first samples of successive iterations |
| cfg_last_s | input | 12 | Data samples per iteration minus one |
| cfg_last_i | input | 12 | Iterations minus one |
| cfg_fft_log2 | input | 4 | Log2 of the FFT length (values above 12 act as 12) |
| cfg_real | input | 1 | 1: real data, imaginary output forced to zero |
| cfg_wide | input | 1 | 0: 16-bit parts, 1: 32-bit parts |
| cfg_signed | input | 1 | Parts are two's complement |
| cfg_shift | input | 4 | Pad shift (16-bit mode) or MSB clip count (32-bit mode), values above 8 act as 8 |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read byte address |
| mem_rvalid | input | 1 | Response valid, `LAT` cycles after a request |
| mem_rdata | input | 64 | Response data, lowest part in the lowest bits |
| out_valid | output | 1 | Output sample valid |
| out_re | output | 24 | Real part |
| out_im | output | 24 | Imaginary part |
| done | output | 1 | Job-finished pulse |

## Verification
A wrong sample or iteration counter shows up at the ports as a shifted read address or a zero slot in the wrong place. It surfaces `LAT+1` cycles later, as a sample that does not match its expected position. A tag that falls out of step with its memory response shows up the same way. A lost or extra slot changes the number of outputs and moves `done`, so it is caught when the job ends. Errors in the narrowing logic, such as a wrong saturation limit or a wrong bit window, appear in the first sample whose upper bits exercise them, so the bench uses address-derived data with varied upper bits.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_PAD   = 2'd2,
        S_DRAIN = 2'd3
    } walk_state_e;

    // Sideband carried alongside each issued slot through the latency pipe
    typedef struct packed {
        logic v;     // slot issued
        logic pad;   // zero slot, no memory read
        logic fin;   // final slot of the job
    } slot_tag_t;

endpackage

// File: rtl/sfmt_conv.sv
module sfmt_conv #(
    parameter int XW   = 32,
    parameter int NW   = 16,
    parameter int OW   = 24,
    parameter int SHW  = 4,
    parameter int MAXS = 8
) (
    input  logic [XW-1:0]  raw,
    input  logic           wide,
    input  logic           sgn,
    input  logic [SHW-1:0] shift,
    output logic [OW-1:0]  res
);

    logic [SHW-1:0] n;
    logic [OW-1:0]  ext;
    logic [OW-1:0]  widened;
    logic [OW-1:0]  kept;
    logic [OW-1:0]  sat_s;
    logic [XW-1:0]  top_bits;
    logic [XW-1:0]  top_ones;
    logic [XW-1:0]  dropped;

    always_comb begin
        n        = (shift > SHW'(MAXS)) ? SHW'(MAXS) : shift;
        ext      = sgn ? OW'($signed(raw[NW-1:0])) : OW'(raw[NW-1:0]);
        widened  = ext << n;
        kept     = OW'(raw >> (MAXS - n));
        top_bits = raw >> (XW - 1 - n);
        top_ones = (XW'(1) << (n + 1)) - XW'(1);
        dropped  = raw >> (XW - n);
        sat_s    = raw[XW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
        if (!wide) begin
            res = widened;
        end else if (sgn) begin
            res = (top_bits == '0 || top_bits == top_ones) ? kept : sat_s;
        end else begin
            res = (dropped == '0) ? kept : '1;
        end
    end

endmodule

// File: rtl/sfmt_walk.sv
module sfmt_walk
    import sfmt_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 12,
    parameter int LGW   = 4,
    parameter int SHW   = 4,
    parameter int MAXLG = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  stride_s,
    input  logic [AW-1:0]  stride_i,
    input  logic [CW-1:0]  last_s,
    input  logic [CW-1:0]  last_i,
    input  logic [LGW-1:0] fft_lg,
    input  logic           real_in,
    input  logic           wide_in,
    input  logic           sgn_in,
    input  logic [SHW-1:0] shift_in,
    input  logic           fin_seen,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output slot_tag_t      tag,
    output logic           real_q,
    output logic           wide_q,
    output logic           sgn_q,
    output logic [SHW-1:0] shift_q
);

    localparam int IW = CW + 1;

    walk_state_e    st, st_nx;
    logic [IW-1:0]  idx;
    logic [IW-1:0]  fft_n;
    logic [IW-1:0]  span_last;
    logic [CW-1:0]  iter;
    logic [CW-1:0]  ls_q, li_q;
    logic [AW-1:0]  addr_q, ibase_q, ss_q, is_q;
    logic [LGW-1:0] lg_q, lg_eff;
    logic           data_end, iter_end, job_end;

    // Slot bookkeeping for the current iteration
    always_comb begin
        lg_eff    = (lg_q > LGW'(MAXLG)) ? LGW'(MAXLG) : lg_q;
        fft_n     = IW'(1) << lg_eff;
        span_last = ((fft_n - IW'(1)) > {1'b0, ls_q}) ? (fft_n - IW'(1)) : {1'b0, ls_q};
        data_end  = (st == S_READ) && (idx == {1'b0, ls_q});
        iter_end  = (data_end && (span_last == {1'b0, ls_q})) ||
                    ((st == S_PAD) && (idx == span_last));
        job_end   = iter_end && (iter == li_q);
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (start) st_nx = S_READ;
            S_READ: begin
                if (job_end)                    st_nx = S_DRAIN;
                else if (data_end && !iter_end) st_nx = S_PAD;
            end
            S_PAD: begin
                if (job_end)       st_nx = S_DRAIN;
                else if (iter_end) st_nx = S_READ;
            end
            S_DRAIN: if (fin_seen) st_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Counters, addresses and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            iter    <= '0;
            addr_q  <= '0;
            ibase_q <= '0;
            ss_q    <= '0;
            is_q    <= '0;
            ls_q    <= '0;
            li_q    <= '0;
            lg_q    <= '0;
            real_q  <= 1'b0;
            wide_q  <= 1'b0;
            sgn_q   <= 1'b0;
            shift_q <= '0;
        end else if (st == S_IDLE && start) begin
            idx     <= '0;
            iter    <= '0;
            addr_q  <= base;
            ibase_q <= base;
            ss_q    <= stride_s;
            is_q    <= stride_i;
            ls_q    <= last_s;
            li_q    <= last_i;
            lg_q    <= fft_lg;
            real_q  <= real_in;
            wide_q  <= wide_in;
            sgn_q   <= sgn_in;
            shift_q <= shift_in;
        end else if (st == S_READ || st == S_PAD) begin
            if (iter_end) begin
                idx     <= '0;
                iter    <= iter + CW'(1);
                ibase_q <= ibase_q + is_q;
                addr_q  <= ibase_q + is_q;
            end else begin
                idx     <= idx + IW'(1);
                addr_q  <= addr_q + ss_q;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        mem_req  = (st == S_READ);
        mem_addr = addr_q;
        tag.v    = (st == S_READ) || (st == S_PAD);
        tag.pad  = (st == S_PAD);
        tag.fin  = job_end;
    end

endmodule

// File: rtl/sfmt_top.sv
module sfmt_top
    import sfmt_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 12,
    parameter int LGW   = 4,
    parameter int SHW   = 4,
    parameter int PW    = 24,
    parameter int DW    = 64,
    parameter int LAT   = 2,
    parameter int MAXSH = 8,
    parameter int MAXLG = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  cfg_base,
    input  logic [AW-1:0]  cfg_stride_s,
    input  logic [AW-1:0]  cfg_stride_i,
    input  logic [CW-1:0]  cfg_last_s,
    input  logic [CW-1:0]  cfg_last_i,
    input  logic [LGW-1:0] cfg_fft_log2,
    input  logic           cfg_real,
    input  logic           cfg_wide,
    input  logic           cfg_signed,
    input  logic [SHW-1:0] cfg_shift,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata,
    output logic           out_valid,
    output logic [PW-1:0]  out_re,
    output logic [PW-1:0]  out_im,
    output logic           done
);

    localparam int HW = DW / 2;
    localparam int QW = DW / 4;

    slot_tag_t      head_tag;
    slot_tag_t      pipe_q [LAT];
    logic           tail_v, tail_pad, tail_fin;
    logic           real_q, wide_q, sgn_q;
    logic [SHW-1:0] shift_q;
    logic           out_fin;
    logic           fin_seen;
    logic [HW-1:0]  raw  [2];
    logic [PW-1:0]  part [2];

    assign fin_seen = out_valid && out_fin;

    sfmt_walk #(
        .AW(AW), .CW(CW), .LGW(LGW), .SHW(SHW), .MAXLG(MAXLG)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .base     (cfg_base),
        .stride_s (cfg_stride_s),
        .stride_i (cfg_stride_i),
        .last_s   (cfg_last_s),
        .last_i   (cfg_last_i),
        .fft_lg   (cfg_fft_log2),
        .real_in  (cfg_real),
        .wide_in  (cfg_wide),
        .sgn_in   (cfg_signed),
        .shift_in (cfg_shift),
        .fin_seen (fin_seen),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .tag      (head_tag),
        .real_q   (real_q),
        .wide_q   (wide_q),
        .sgn_q    (sgn_q),
        .shift_q  (shift_q)
    );

    // Tag pipe matching the fixed read latency
    for (genvar g = 0; g < LAT; g++) begin : g_pipe
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pipe_q[g] <= '0;
            else if (g == 0) pipe_q[g] <= head_tag;
            else             pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
        end
    end

    assign tail_v   = pipe_q[LAT-1].v;
    assign tail_pad = pipe_q[LAT-1].pad;
    assign tail_fin = pipe_q[LAT-1].fin;

    // Part selection from the response word
    always_comb begin
        raw[0] = wide_q ? mem_rdata[HW-1:0] : HW'(mem_rdata[QW-1:0]);
        if (real_q)      raw[1] = '0;
        else if (wide_q) raw[1] = mem_rdata[DW-1:HW];
        else             raw[1] = HW'(mem_rdata[2*QW-1:QW]);
    end

    for (genvar p = 0; p < 2; p++) begin : g_conv
        sfmt_conv #(
            .XW(HW), .NW(QW), .OW(PW), .SHW(SHW), .MAXS(MAXSH)
        ) u_conv (
            .raw   (raw[p]),
            .wide  (wide_q),
            .sgn   (sgn_q),
            .shift (shift_q),
            .res   (part[p])
        );
    end

    // Output register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fin   <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= tail_v && (tail_pad || mem_rvalid);
            out_fin   <= tail_v && tail_fin;
            out_re    <= tail_pad ? '0 : part[0];
            out_im    <= (tail_pad || real_q) ? '0 : part[1];
            done      <= fin_seen;
        end
    end

endmodule

// File: rtl/sfmt_chk.sv
module sfmt_chk #(
    parameter int PW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic [PW-1:0] out_re,
    input logic [PW-1:0] out_im,
    input logic          done,
    input logic          mem_rvalid,
    input logic          tail_v,
    input logic          tail_pad,
    input logic          real_q
);

    // R10: done lasts a single cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done follows an output sample
    a_r10_done_after_out: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid));

    // R4: a padded slot leaves as a zero sample
    a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_v && tail_pad) |=> (out_valid && out_re == '0 && out_im == '0));

    // R3: every data slot meets its memory response
    a_r3_resp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_v && !tail_pad) |-> mem_rvalid);

    // R5: real mode keeps the imaginary output at zero
    a_r5_imag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && real_q) |-> (out_im == '0));

endmodule

bind sfmt_top sfmt_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_re     (out_re),
    .out_im     (out_im),
    .done       (done),
    .mem_rvalid (mem_rvalid),
    .tail_v     (tail_v),
    .tail_pad   (tail_pad),
    .real_q     (real_q)
);

// File: tb/sfmt_top_tb_top.sv
`timescale 1ns/1ps
module sfmt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cfg_base = '0, cfg_stride_s = '0, cfg_stride_i = '0;
    logic [11:0] cfg_last_s = '0, cfg_last_i = '0;
    logic [3:0]  cfg_fft_log2 = '0, cfg_shift = '0;
    logic        cfg_real = 1'b0, cfg_wide = 1'b0, cfg_signed = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        out_valid;
    logic [23:0] out_re, out_im;
    logic        done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sfmt_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_base(cfg_base), .cfg_stride_s(cfg_stride_s), .cfg_stride_i(cfg_stride_i),
        .cfg_last_s(cfg_last_s), .cfg_last_i(cfg_last_i), .cfg_fft_log2(cfg_fft_log2),
        .cfg_real(cfg_real), .cfg_wide(cfg_wide), .cfg_signed(cfg_signed), .cfg_shift(cfg_shift),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .done(done)
    );

    function automatic logic [63:0] memword(input logic [15:0] a);
        logic [15:0] p3, p2, p1, p0;
        p3 = (a * 16'h9e37) ^ 16'h7c01;
        p2 = a ^ 16'h8421;
        p1 = (a * 16'h003b) + 16'h0f0f;
        p0 = ~a;
        return {p3, p2, p1, p0};
    endfunction

    // Memory model: fixed two-cycle latency
    logic        m_v1 = 1'b0, m_v2 = 1'b0;
    logic [15:0] m_a1 = '0, m_a2 = '0;
    always @(posedge clk) begin
        m_v1 <= mem_req;
        m_a1 <= mem_addr;
        m_v2 <= m_v1;
        m_a2 <= m_a1;
    end
    assign mem_rvalid = m_v2;
    assign mem_rdata  = m_v2 ? memword(m_a2) : 64'h0bad_0bad_0bad_0bad;

    function automatic logic [23:0] ref_conv(input logic [31:0] raw, input bit wd, input bit sg, input int sh);
        int     n;
        longint v;
        n = (sh > 8) ? 8 : sh;
        if (!wd) begin
            v = sg ? longint'($signed(raw[15:0])) : longint'(raw[15:0]);
            v = v * (longint'(1) << n);
            return v[23:0];
        end
        v = sg ? longint'($signed(raw)) : longint'(raw);
        v = v >>> (8 - n);
        if (sg) begin
            if (v > 64'sd8388607)  return 24'h7fffff;
            if (v < -64'sd8388608) return 24'h800000;
        end else begin
            if (v > 64'sd16777215) return 24'hffffff;
        end
        return v[23:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic [23:0] exp_re [0:255];
    logic [23:0] exp_im [0:255];
    int    exp_n = 0, exp_reads = 0;
    int    ocnt = 0, reads = 0, done_cnt = 0;
    int    first_cyc = 0, last_cyc = 0, done_cyc = 0;
    string cur_req = "R1";

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) reads++;
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
            if (out_valid) begin
                if (ocnt == 0) first_cyc = cyc;
                last_cyc = cyc;
                if (ocnt < exp_n)
                    chk({out_re, out_im} == {exp_re[ocnt], exp_im[ocnt]}, cur_req,
                        $sformatf("sample %0d {re,im}", ocnt),
                        longint'({out_re, out_im}), longint'({exp_re[ocnt], exp_im[ocnt]}));
                else
                    chk(1'b0, cur_req, "extra sample", longint'(ocnt), longint'(exp_n));
                ocnt++;
            end
        end
    end

    task automatic run_job(input logic [15:0] b, input logic [15:0] ss, input logic [15:0] is,
                           input int ls, input int li, input int lg,
                           input bit rl, input bit wd, input bit sg, input int sh,
                           input bit poke, input string req);
        int          lge, span, waited, st_cyc;
        logic [15:0] a;
        logic [63:0] w;
        lge  = (lg > 12) ? 12 : lg;
        span = ((1 << lge) > ls + 1) ? (1 << lge) : ls + 1;
        exp_n = 0;
        exp_reads = 0;
        for (int i = 0; i <= li; i++) begin
            for (int s = 0; s < span; s++) begin
                if (s <= ls) begin
                    a = b + 16'(i) * is + 16'(s) * ss;
                    w = memword(a);
                    exp_re[exp_n] = ref_conv(wd ? w[31:0] : {16'h0, w[15:0]}, wd, sg, sh);
                    exp_im[exp_n] = rl ? 24'h0 : ref_conv(wd ? w[63:32] : {16'h0, w[31:16]}, wd, sg, sh);
                    exp_reads++;
                end else begin
                    exp_re[exp_n] = '0;
                    exp_im[exp_n] = '0;
                end
                exp_n++;
            end
        end
        @(negedge clk);
        cur_req = req;
        ocnt = 0; reads = 0; done_cnt = 0;
        first_cyc = 0; last_cyc = 0; done_cyc = 0;
        cfg_base = b; cfg_stride_s = ss; cfg_stride_i = is;
        cfg_last_s = 12'(ls); cfg_last_i = 12'(li); cfg_fft_log2 = 4'(lg);
        cfg_real = rl; cfg_wide = wd; cfg_signed = sg; cfg_shift = 4'(sh);
        start = 1'b1;
        st_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            cfg_base = ~b; cfg_last_s = 12'd0; cfg_wide = ~wd; cfg_shift = 4'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        repeat (4) @(negedge clk);
        chk(ocnt == exp_n, req, "R9 output count", longint'(ocnt), longint'(exp_n));
        chk(reads == exp_reads, req, "R2 read count", longint'(reads), longint'(exp_reads));
        chk(done_cnt == 1, req, "R10 done pulses", longint'(done_cnt), 1);
        chk(done_cyc == last_cyc + 1, req, "R10 done timing", longint'(done_cyc), longint'(last_cyc + 1));
        chk(first_cyc == st_cyc + 4, req, "R3 first-output latency", longint'(first_cyc), longint'(st_cyc + 4));
        chk(last_cyc - first_cyc == exp_n - 1, req, "R3 gap-free span",
            longint'(last_cyc - first_cyc), longint'(exp_n - 1));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!mem_req, "R1", "mem_req after reset", longint'(mem_req), 0);
            chk(!out_valid, "R1", "out_valid after reset", longint'(out_valid), 0);
            chk(!done, "R1", "done after reset", longint'(done), 0);
        end
    endtask

    task automatic t_complex16;   // R2 R6 R7
        run_job(16'h0100, 16'd4, 16'd0, 7, 0, 3, 1'b0, 1'b0, 1'b1, 0, 1'b0, "R2 R6 complex16");
    endtask

    task automatic t_iterations;  // R9 R3
        run_job(16'h0200, 16'd16, 16'd4, 3, 3, 2, 1'b0, 1'b0, 1'b1, 1, 1'b0, "R9 iterations");
    endtask

    task automatic t_zero_pad;    // R4
        run_job(16'h1000, 16'd8, 16'd64, 4, 1, 3, 1'b0, 1'b0, 1'b0, 2, 1'b0, "R4 padded");
        run_job(16'h2000, 16'd4, 16'd0, 9, 0, 3, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R4 no-pad");
    endtask

    task automatic t_real_wide;   // R5 R8 R2 wrap
        run_job(16'hfff0, 16'd8, 16'h0020, 5, 1, 3, 1'b1, 1'b1, 1'b1, 4, 1'b0, "R5 R8 real32 wrap");
        run_job(16'h0400, 16'd8, 16'd0, 3, 0, 0, 1'b1, 1'b0, 1'b1, 2, 1'b0, "R5 real16");
    endtask

    task automatic t_widen16;     // R7
        run_job(16'h3000, 16'd4, 16'd0, 7, 0, 0, 1'b0, 1'b0, 1'b0, 5, 1'b0, "R7 unsigned shift5");
        run_job(16'h3100, 16'd4, 16'd0, 7, 0, 0, 1'b0, 1'b0, 1'b1, 12, 1'b0, "R7 signed clamped shift");
    endtask

    task automatic t_clip32;      // R8 R6
        run_job(16'h5000, 16'd8, 16'd0, 7, 0, 0, 1'b0, 1'b1, 1'b0, 0, 1'b0, "R8 R6 unsigned clip0");
        run_job(16'h5100, 16'd8, 16'd0, 7, 0, 0, 1'b0, 1'b1, 1'b0, 8, 1'b0, "R8 unsigned clip8");
        run_job(16'h5200, 16'd8, 16'd0, 7, 0, 0, 1'b0, 1'b1, 1'b1, 8, 1'b0, "R8 signed clip8");
        run_job(16'h5300, 16'd8, 16'd0, 7, 0, 0, 1'b0, 1'b1, 1'b1, 1, 1'b0, "R8 signed clip1");
    endtask

    task automatic t_busy_start;  // R11
        run_job(16'h0600, 16'd16, 16'd4, 3, 3, 2, 1'b0, 1'b0, 1'b1, 0, 1'b1, "R11 start while busy");
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_complex16();
        t_iterations();
        t_zero_pad();
        t_real_wide();
        t_widen16();
        t_clip32();
        t_busy_start();
        finish_run();
    end

endmodule